// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by reading page table entries from memory. A walk starts when the walker is idle and a request arrives. The request carries a 31-bit virtual address, an access kind and a user/supervisor flag. The walker captures the table base input at that moment. It then reads one entry per level through a memory port that uses a valid/ready request handshake and a response of variable latency.

The virtual address has three fields. The low 12 bits are the page offset, and they pass through untranslated. Bits [30:22] index the top-level table and bits [21:12] index the leaf table. Each entry is 4 bytes wide. The first entry gives the base of the leaf table. The leaf entry gives the physical frame number and the permission flags. A walk ends with one of three results: a translated physical address, a page fault (an entry is not valid) or a protection fault (the leaf entry forbids the access). Only one walk runs at a time.

Top module: `page_walker`

## Requirements
- R1: `reqReady` is high only while no walk is in progress. A request is taken in a cycle where `reqValid` and `reqReady` are both high. After that, `reqReady` stays low until the response for that request has been delivered.
- R2: The first memory read of a walk goes to address `ptBase + vaddr[30:22]*4`, taken modulo 2^27.
- R3: When the top-level entry is valid, the second read goes to address `(entry[30:16] << 12) + vaddr[21:12]*4`, taken modulo 2^27.
- R4: Entry bit 0 is the valid flag. If the top-level entry has bit 0 clear, the walk ends after that single read with status 01 (page fault). If the leaf entry has bit 0 clear, the walk ends with status 01 after two reads. A walk never makes more than two reads.
- R5: The leaf entry's flags control access. Bit 1 allows read (kind 00), bit 2 allows write (kind 01) and bit 3 allows execute (kind 10). Kind 11 is always refused. A user request (`reqUser`=1) also needs bit 4. A supervisor request ignores bit 4. A refused access ends with status 10 (protection fault). The flag bits of the top-level entry have no effect.
- R6: A permitted access ends with status 00, and `rspPaddr = {leaf[30:16], vaddr[11:0]}`.
- R7: `memReqValid` stays high, with `memReqAddr` unchanged, until `memReqReady` is seen. Response data is taken in any cycle of the wait in which `memRspValid` is high.
- R8: Each accepted request produces exactly one `rspValid` pulse, one cycle long.
- R9: `ptBase` is sampled only when a request is accepted. Changing it during a walk has no effect on that walk.
- R10: During reset, `reqReady` is 1 and both `memReqValid` and `rspValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ptBase | input | 27 | Physical base address of the top-level table |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle, request can be taken |
| reqVaddr | input | 31 | Virtual address to translate |
| reqKind | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 reserved |
| reqUser | input | 1 | 1 = user access, 0 = supervisor access |
| memReqValid | output | 1 | Entry read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 27 | Byte address of the entry |
| memRspValid | input | 1 | Entry data returned |
| memRspData | input | 32 | Entry contents |
| rspValid | output | 1 | Walk result, one-cycle pulse |
| rspPaddr | output | 27 | Physical address (meaningful when status is 00) |
| rspStatus | output | 2 | 00 ok, 01 page fault, 10 protection fault |

## Verification
The bench goes after several corner cases:
- **Invalid entry at each level.** A walker that ignored the valid bit on the top-level entry would make a stray second read, or would return a translation where a page fault belongs.
- **Maximum indices at both levels, including a table at the highest frame.** A walker that truncated the scaled index, or lost the carry, would read the wrong address.
- **User access to a page without the user flag, and the reserved access kind.** A walker that checked only one flag, or allowed the reserved kind, would grant an access it should refuse.
- **Table flags mixed up between levels.** Top-level entries carry no flags, so a walker that checked permissions on the wrong level would fault where it should succeed.
- **Base changed during a walk.** A walker that read `ptBase` directly instead of its captured copy would start from the wrong table.
- **Stalls on the memory side.** These confirm that the read address holds steady until it is accepted.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // Entry flag positions (leaf permission bits and valid flag)
  localparam int BIT_V   = 0;
  localparam int BIT_RD  = 1;
  localparam int BIT_WR  = 2;
  localparam int BIT_EX  = 3;
  localparam int BIT_USR = 4;
  localparam int FLAG_W  = 5;

  // Number of table levels handled by the walker
  localparam int LEVELS = 2;

  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_EXEC  = 2'b10,
    KIND_RSVD  = 2'b11
  } accKind_e;

  typedef enum logic [1:0] {
    ST_OK         = 2'b00,
    ST_PAGE_FAULT = 2'b01,
    ST_PROT_FAULT = 2'b10
  } walkStatus_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic        capReq;     // latch request and table base
    logic        capBase;    // latch next-level table base from entry
    logic        capResult;  // latch final status and physical address
    walkStatus_e status;     // status to record with capResult
  } dpStrobe_t;

endpackage

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int VA_W    = 31,
  parameter int PA_W    = 27,
  parameter int OFF_W   = 12,
  parameter int TOP_W   = 9,
  parameter int PTE_W   = 32,
  parameter int PPN_LSB = 16,
  parameter int PTE_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic             topLevel,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic [1:0]       reqKind,
  input  logic             reqUser,
  input  logic [PA_W-1:0]  ptBase,
  input  logic [PTE_W-1:0] memRspData,
  output logic [PA_W-1:0]  memReqAddr,
  output logic             entryValid,
  output logic             permOk,
  output logic [PA_W-1:0]  rspPaddr,
  output logic [1:0]       rspStatus
);

  localparam int LOW_W = VA_W - OFF_W - TOP_W;
  localparam int PPN_W = PA_W - OFF_W;

  logic [VA_W-1:0]  vaddrQ;
  accKind_e         kindQ;
  logic             userQ;
  logic [PA_W-1:0]  baseQ;
  logic [PA_W-1:0]  paddrQ;
  walkStatus_e      statusQ;

  logic [TOP_W-1:0] topIdx;
  logic [LOW_W-1:0] lowIdx;
  logic [PA_W-1:0]  idxExt;
  logic [PPN_W-1:0] entryPpn;
  logic [FLAG_W-1:0] entryFlags;
  logic             kindAllowed;

  // Request and walk registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ  <= '0;
      kindQ   <= KIND_READ;
      userQ   <= 1'b0;
      baseQ   <= '0;
      paddrQ  <= '0;
      statusQ <= ST_OK;
    end else begin
      if (strobe.capReq) begin
        vaddrQ <= reqVaddr;
        kindQ  <= accKind_e'(reqKind);
        userQ  <= reqUser;
        baseQ  <= ptBase;
      end
      if (strobe.capBase) begin
        baseQ <= {entryPpn, {OFF_W{1'b0}}};
      end
      if (strobe.capResult) begin
        statusQ <= strobe.status;
        paddrQ  <= {entryPpn, vaddrQ[OFF_W-1:0]};
      end
    end
  end

  // Entry address: table base plus scaled level index
  assign topIdx     = vaddrQ[VA_W-1 -: TOP_W];
  assign lowIdx     = vaddrQ[OFF_W +: LOW_W];
  assign idxExt     = topLevel ? PA_W'(topIdx) : PA_W'(lowIdx);
  assign memReqAddr = baseQ + (idxExt << PTE_SHIFT);

  // Entry decode
  assign entryFlags = memRspData[FLAG_W-1:0];
  assign entryPpn   = memRspData[PPN_LSB +: PPN_W];
  assign entryValid = entryFlags[BIT_V];

  always_comb begin
    unique case (kindQ)
      KIND_READ:  kindAllowed = entryFlags[BIT_RD];
      KIND_WRITE: kindAllowed = entryFlags[BIT_WR];
      KIND_EXEC:  kindAllowed = entryFlags[BIT_EX];
      default:    kindAllowed = 1'b0;
    endcase
  end

  assign permOk = kindAllowed && (!userQ || entryFlags[BIT_USR]);

  assign rspPaddr  = paddrQ;
  assign rspStatus = statusQ;

  logic unusedEntryBits;
  assign unusedEntryBits = ^{memRspData[PTE_W-1:PPN_LSB+PPN_W], memRspData[PPN_LSB-1:FLAG_W]};

  // A granted result must come from a valid, permitted leaf
  assert_grant_needs_perm_R5 : assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capResult && strobe.status == ST_OK) |-> (entryValid && permOk));

  // A fault of the page kind must come from a clear valid flag
  assert_pf_needs_invalid_R4 : assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capResult && strobe.status == ST_PAGE_FAULT) |-> !entryValid);

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      memReqReady,
  input  logic      memRspValid,
  input  logic      entryValid,
  input  logic      permOk,
  output logic      reqReady,
  output logic      memReqValid,
  output logic      rspValid,
  output logic      topLevel,
  output dpStrobe_t strobe
);

  localparam int CNT_W = $clog2(LEVELS + 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_DONE} walkState_e;

  walkState_e state, stateNext;
  logic [CNT_W-1:0] readCnt;

  always_comb begin
    stateNext        = state;
    strobe.capReq    = 1'b0;
    strobe.capBase   = 1'b0;
    strobe.capResult = 1'b0;
    strobe.status    = ST_OK;
    unique case (state)
      S_IDLE: if (reqValid) begin
        strobe.capReq = 1'b1;
        stateNext     = S_REQ;
      end
      S_REQ: if (memReqReady) stateNext = S_WAIT;
      S_WAIT: if (memRspValid) begin
        if (!entryValid) begin
          strobe.capResult = 1'b1;
          strobe.status    = ST_PAGE_FAULT;
          stateNext        = S_DONE;
        end else if (topLevel) begin
          strobe.capBase = 1'b1;
          stateNext      = S_REQ;
        end else begin
          strobe.capResult = 1'b1;
          strobe.status    = permOk ? ST_OK : ST_PROT_FAULT;
          stateNext        = S_DONE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      topLevel <= 1'b1;
      readCnt  <= '0;
    end else begin
      state <= stateNext;
      if (strobe.capReq) begin
        topLevel <= 1'b1;
        readCnt  <= '0;
      end else begin
        if (strobe.capBase) topLevel <= 1'b0;
        if (memReqValid && memReqReady) readCnt <= readCnt + 1'b1;
      end
    end
  end

  assign reqReady    = (state == S_IDLE);
  assign memReqValid = (state == S_REQ);
  assign rspValid    = (state == S_DONE);

  assert_walk_exclusive_R1 : assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_req_hold_R7 : assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid);

  assert_rsp_pulse_R8 : assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_read_budget_R4 : assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (int'(readCnt) < LEVELS));

endmodule

// File: rtl/page_walker.sv
module page_walker
  import ptw_pkg::*;
#(
  parameter int VA_W    = 31,
  parameter int PA_W    = 27,
  parameter int OFF_W   = 12,
  parameter int TOP_W   = 9,
  parameter int PTE_W   = 32,
  parameter int PPN_LSB = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PA_W-1:0]  ptBase,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic [1:0]       reqKind,
  input  logic             reqUser,
  output logic             memReqValid,
  input  logic             memReqReady,
  output logic [PA_W-1:0]  memReqAddr,
  input  logic             memRspValid,
  input  logic [PTE_W-1:0] memRspData,
  output logic             rspValid,
  output logic [PA_W-1:0]  rspPaddr,
  output logic [1:0]       rspStatus
);

  localparam int PTE_SHIFT = $clog2(PTE_W / 8);

  dpStrobe_t strobe;
  logic      topLevel;
  logic      entryValid;
  logic      permOk;

  ptw_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .entryValid  (entryValid),
    .permOk      (permOk),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .rspValid    (rspValid),
    .topLevel    (topLevel),
    .strobe      (strobe)
  );

  ptw_datapath #(
    .VA_W      (VA_W),
    .PA_W      (PA_W),
    .OFF_W     (OFF_W),
    .TOP_W     (TOP_W),
    .PTE_W     (PTE_W),
    .PPN_LSB   (PPN_LSB),
    .PTE_SHIFT (PTE_SHIFT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .topLevel   (topLevel),
    .reqVaddr   (reqVaddr),
    .reqKind    (reqKind),
    .reqUser    (reqUser),
    .ptBase     (ptBase),
    .memRspData (memRspData),
    .memReqAddr (memReqAddr),
    .entryValid (entryValid),
    .permOk     (permOk),
    .rspPaddr   (rspPaddr),
    .rspStatus  (rspStatus)
  );

  assert_addr_stable_R7 : assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> $stable(memReqAddr));

endmodule

// File: tb/page_walker_bench.sv
`timescale 1ns/1ps
module page_walker_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [26:0] ptBase = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [30:0] reqVaddr = '0;
  logic [1:0]  reqKind = '0;
  logic        reqUser = 1'b0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [26:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        rspValid;
  logic [26:0] rspPaddr;
  logic [1:0]  rspStatus;

  always #2.5 clk = ~clk;

  page_walker u_page_walker (
    .clk(clk), .rstN(rstN), .ptBase(ptBase),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr),
    .reqKind(reqKind), .reqUser(reqUser),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .rspValid(rspValid), .rspPaddr(rspPaddr), .rspStatus(rspStatus)
  );

  typedef struct {
    logic [26:0] pa;
    logic [1:0]  st;
    int          nreads;
  } expItem_t;

  typedef struct {
    logic [26:0] addr;
    int          level;
  } addrItem_t;

  expItem_t  expQ[$];
  addrItem_t addrQ[$];
  logic [31:0] mem [int unsigned];
  int compared = 0;
  int mismatched = 0;
  int readsThisWalk = 0;

  function automatic logic [31:0] rd(input logic [26:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 32'h0;
  endfunction

  function automatic logic [31:0] mkPte(input logic [14:0] ppn, input logic [4:0] flags);
    return {1'b0, ppn, 11'b0, flags};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Build expectations from the requirements and push them
  task automatic walk(input logic [30:0] va, input logic [1:0] kind, input logic user,
                      input logic [26:0] base, input logic [26:0] baseAfter);
    expItem_t e;
    addrItem_t ai;
    logic [31:0] e0, e1;
    logic [26:0] a0, a1;
    logic ok;
    a0 = base + 27'({va[30:22], 2'b00});
    e0 = rd(a0);
    ai.addr = a0; ai.level = 0; addrQ.push_back(ai);
    e.pa = '0; e.nreads = 1;
    if (!e0[0]) e.st = 2'b01;
    else begin
      a1 = {e0[30:16], 12'h000} + 27'({va[21:12], 2'b00});
      e1 = rd(a1);
      ai.addr = a1; ai.level = 1; addrQ.push_back(ai);
      e.nreads = 2;
      if (!e1[0]) e.st = 2'b01;
      else begin
        case (kind)
          2'b00: ok = e1[1];
          2'b01: ok = e1[2];
          2'b10: ok = e1[3];
          default: ok = 1'b0;
        endcase
        if (user && !e1[4]) ok = 1'b0;
        e.st = ok ? 2'b00 : 2'b10;
        e.pa = {e1[30:16], va[11:0]};
      end
    end
    expQ.push_back(e);
    @(negedge clk);
    ptBase = base; reqVaddr = va; reqKind = kind; reqUser = user; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    ptBase = baseAfter;
    check("R1 busy after accept", {31'b0, reqReady}, 32'h0);
  endtask

  // Memory responder with random stalls and latency
  initial begin
    bit pending = 0;
    int cnt = 0;
    logic [26:0] heldAddr = '0;
    addrItem_t ai;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (pending && cnt == 0) begin
        memRspValid = 1'b1;
        memRspData  = rd(heldAddr);
        pending = 0;
      end else if (pending) cnt--;
      memReqReady = rstN && !pending && ($urandom_range(0, 2) != 0);
      if (memReqReady && memReqValid) begin
        pending = 1;
        cnt = $urandom_range(0, 3);
        heldAddr = memReqAddr;
        readsThisWalk++;
        if (addrQ.size() == 0) begin
          compared++; mismatched++;
          $display("FAIL R4: actual extra read at %0h expected none", memReqAddr);
        end else begin
          ai = addrQ.pop_front();
          if (ai.level == 0) check("R2 top-level entry address", 32'(memReqAddr), 32'(ai.addr));
          else check("R3 leaf entry address", 32'(memReqAddr), 32'(ai.addr));
        end
      end
    end
  end

  // Monitor: compare results as they come out
  initial begin
    expItem_t e;
    forever begin
      @(negedge clk);
      if (rspValid) begin
        if (expQ.size() == 0) begin
          compared++; mismatched++;
          $display("FAIL R8: actual unexpected response expected none");
        end else begin
          e = expQ.pop_front();
          check("R4/R5/R6 status", 32'(rspStatus), 32'(e.st));
          if (e.st == 2'b00) check("R6 physical address", 32'(rspPaddr), 32'(e.pa));
          check("R4 read count", 32'(readsThisWalk), 32'(e.nreads));
        end
        readsThisWalk = 0;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  localparam logic [26:0] BASE_A = 27'h0100000;
  localparam logic [26:0] BASE_B = 27'h0300000;

  function automatic logic [30:0] va(input logic [8:0] t, input logic [9:0] l, input logic [11:0] o);
    return {t, l, o};
  endfunction

  initial begin
    // Tables. Top-level entries carry no permission flags (R5: ignored).
    mem[int'(BASE_A + 27'(5*4))]   = mkPte(15'h0123, 5'b00001);
    mem[int'(BASE_A + 27'(511*4))] = mkPte(15'h7FFF, 5'b00001);
    mem[int'(BASE_A + 27'(3*4))]   = mkPte(15'h0200, 5'b00001);
    mem[int'(27'h0123000 + 27'(0*4))]    = mkPte(15'h0ABC, 5'b00011);
    mem[int'(27'h0123000 + 27'(1*4))]    = mkPte(15'h1111, 5'b00111);
    mem[int'(27'h0123000 + 27'(2*4))]    = mkPte(15'h2222, 5'b11001);
    mem[int'(27'h0123000 + 27'(3*4))]    = mkPte(15'h3333, 5'b01111);
    mem[int'(27'h0123000 + 27'(1023*4))] = mkPte(15'h7FFF, 5'b11111);
    mem[int'(27'h7FFF000 + 27'(1023*4))] = mkPte(15'h0001, 5'b10011);
    mem[int'(BASE_B + 27'(5*4))]   = mkPte(15'h0400, 5'b00001);
    mem[int'(27'h0400000)]         = mkPte(15'h5555, 5'b00011);

    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10 reqReady in reset", {31'b0, reqReady}, 32'h1);
    check("R10 memReqValid in reset", {31'b0, memReqValid}, 32'h0);
    check("R10 rspValid in reset", {31'b0, rspValid}, 32'h0);
    rstN = 1'b1;

    walk(va(5, 0, 12'h345), 2'b00, 1'b0, BASE_A, BASE_A);   // R6 read ok
    walk(va(5, 0, 12'h345), 2'b01, 1'b0, BASE_A, BASE_A);   // R5 write refused
    walk(va(5, 1, 12'h010), 2'b01, 1'b0, BASE_A, BASE_A);   // R6 write ok
    walk(va(5, 2, 12'hFFF), 2'b10, 1'b1, BASE_A, BASE_A);   // R5 user exec ok
    walk(va(5, 3, 12'h001), 2'b00, 1'b1, BASE_A, BASE_A);   // R5 user, no U flag
    walk(va(5, 3, 12'h001), 2'b00, 1'b0, BASE_A, BASE_A);   // R5 supervisor ignores U
    walk(va(5, 3, 12'h001), 2'b11, 1'b0, BASE_A, BASE_A);   // R5 reserved kind
    walk(va(7, 0, 12'h000), 2'b00, 1'b0, BASE_A, BASE_A);   // R4 top invalid
    walk(va(3, 9, 12'h000), 2'b00, 1'b0, BASE_A, BASE_A);   // R4 leaf invalid
    walk(va(511, 1023, 12'hABC), 2'b00, 1'b1, BASE_A, BASE_A); // R2/R3 max indices
    walk(va(5, 1023, 12'h7FF), 2'b01, 1'b1, BASE_A, BASE_A);   // R6 top frame
    walk(va(5, 0, 12'h123), 2'b00, 1'b0, BASE_B, BASE_B);   // R2 other base
    walk(va(5, 1, 12'h222), 2'b01, 1'b0, BASE_A, BASE_B);   // R9 base changed mid-walk
    walk(va(5, 0, 12'h456), 2'b00, 1'b0, BASE_B, 27'h5555555); // R9 again
    for (int i = 0; i < 24; i++) begin
      logic [8:0] t;
      logic [9:0] l;
      case ($urandom_range(0, 4))
        0: t = 9'd5; 1: t = 9'd511; 2: t = 9'd3; 3: t = 9'd7; default: t = 9'd0;
      endcase
      l = ($urandom_range(0, 4) == 4) ? 10'd1023 : 10'($urandom_range(0, 3));
      walk(va(t, l, 12'($urandom)), 2'($urandom), 1'($urandom), BASE_A, BASE_A);
    end

    while (expQ.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    check("R8 no pending reads", 32'(addrQ.size()), 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule